// File: doc/BRIEF.md
# Register-Mapped SPI Host Controller

This block is a serial peripheral interface host that software drives through a small word-wide register bus. It keeps a serial clock divisor, the clock polarity and phase, a frame format (lane code, bit order, direction flag, frame length), a chip-select number, a per-line idle level register and a chip-select policy. Bytes written to the transmit data register go into an eight-entry queue. The shift engine takes one byte at a time and sends a frame of 1 to 8 bits on a single data lane. Every frame also captures one byte from the input line into an eight-entry receive queue.

The bus uses 8-bit byte addresses and has no wait states. Read data is combinational from the address. A read strobe on the receive data address removes the head byte. Chip select can follow one of three policies. It can be asserted only while a frame runs, or kept asserted after a frame until software changes the selection, or never driven by the engine. The idle level of each chip-select line is programmable, and the active level of the selected line is the inverse of its idle level.

Top module: `spi_host`

## Requirements
- R1: After reset, these reads are expected: divisor (0x00) 3, clock mode (0x04) 0, chip-select number (0x10) 0, idle levels (0x14) all ones (0xF for four lines), chip-select policy (0x18) 0, format (0x40) 0x0008_0000, transmit data (0x48) 0, receive data (0x4C) 0x8000_0000. Configuration writes read back masked to their field widths, and the divisor keeps 12 bits. The flash control address (0x60) always reads zero.
- R2: SCK changes level exactly every div+1 clock cycles during a frame, so its frequency is clk/(2*(div+1)). Between frames SCK rests at the polarity bit (bit 1 of 0x04).
- R3: With phase (bit 0 of 0x04) clear, MOSI is valid before the first edge and both sides sample on the leading edge. With phase set, both sides sample on the trailing edge. This holds in all four polarity/phase combinations.
- R4: The frame length is bits 19:16 of 0x40. A value of 0 sends 1 bit, and values above 8 send 8 bits. Bit 2 of 0x40 set sends LSB first, clear sends MSB first. Only the low N bits of the transmit byte are sent.
- R5: Each frame pushes one received byte into the receive queue, right-aligned in bits N-1:0 with zeros above.
- R6: Reading 0x48 returns bit 31 set when the transmit queue holds 8 bytes. A write to 0x48 pushes bits 7:0. A write while the queue is full is dropped.
- R7: Reading 0x4C returns bit 31 set when the receive queue is empty, and otherwise the head byte in bits 7:0. A read strobe with data present pops one entry. No frame starts while the receive queue is full, and bytes come out in the order they were sent.
- R8: Policy 0 (bits 1:0 of 0x18) asserts the selected line only while a frame runs.
- R9: Policy 2 asserts the selected line when a frame starts and keeps it asserted afterwards. The assertion ends on any of three writes: a write that changes the policy value, a write that changes the chip-select number, or a write to 0x14 that alters the idle bit of the selected line. Writes that change none of these leave it asserted.
- R10: Policy 3 never asserts any line. Frames still run and still receive.
- R11: Every line rests at its bit in 0x14, and the active level of the selected line is the inverse of that bit. A chip-select number at or above the line count selects no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (pops the receive queue at 0x4C) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csOut | output | NumCs | Chip-select lines |

## Verification
The assertions assume that software leaves the divisor, clock mode and format registers alone while a frame is in flight. The shift engine reads them live. The stimulus therefore changes configuration only after the previous frame's byte has reached the receive queue. The assertions also assume that the read strobe is raised only while the read address is stable. The bench drives the bus on falling clock edges. It never writes a mid-frame configuration value, and it uses policy changes only between frames.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;
  localparam logic [7:0] AdrDiv    = 8'h00;
  localparam logic [7:0] AdrMode   = 8'h04;
  localparam logic [7:0] AdrCsId   = 8'h10;
  localparam logic [7:0] AdrCsDef  = 8'h14;
  localparam logic [7:0] AdrCsPol  = 8'h18;
  localparam logic [7:0] AdrFmt    = 8'h40;
  localparam logic [7:0] AdrTxData = 8'h48;
  localparam logic [7:0] AdrRxData = 8'h4C;
  localparam logic [7:0] AdrFlash  = 8'h60;

  localparam logic [1:0] CsAuto = 2'd0;
  localparam logic [1:0] CsHold = 2'd2;
  localparam logic [1:0] CsOff  = 2'd3;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic loadFrame;
    logic shiftOut;
    logic sampleIn;
    logic pushRx;
  } dpStrobes_t;
endpackage

// File: rtl/spi_host_fifo.sv
`timescale 1ns/1ps
module spi_host_fifo #(
  parameter int Depth = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] pushData,
  input  logic       pop,
  output logic [7:0] headData,
  output logic       empty,
  output logic       full
);
  localparam int PtrW = $clog2(Depth);
  localparam int CntW = PtrW + 1;

  logic [7:0]      mem [Depth];
  logic [PtrW-1:0] wrPtr, rdPtr;
  logic [CntW-1:0] count;
  logic            doPush, doPop;

  assign empty    = (count == '0);
  assign full     = (count == CntW'(Depth));
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/spi_host_dp.sv
`timescale 1ns/1ps
module spi_host_dp
  import spi_host_pkg::*;
#(
  parameter int Depth = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dpStrobes_t strobes,
  input  logic [7:0] wrByte,
  input  logic [3:0] frameLen,
  input  logic       lsbFirst,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] rxHead,
  output logic       txEmpty,
  output logic       txFull,
  output logic       rxEmpty,
  output logic       rxFull
);
  logic [7:0] txHead, txShift, rxShift, rxNext, rxByte;

  spi_host_fifo #(.Depth(Depth)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(strobes.txPush), .pushData(wrByte),
    .pop(strobes.loadFrame), .headData(txHead), .empty(txEmpty), .full(txFull));

  spi_host_fifo #(.Depth(Depth)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(strobes.pushRx), .pushData(rxByte),
    .pop(strobes.rxPop), .headData(rxHead), .empty(rxEmpty), .full(rxFull));

  assign mosi = lsbFirst ? txShift[0] : txShift[3'(frameLen - 4'd1)];

  always_comb begin
    rxNext = rxShift;
    if (strobes.sampleIn)
      rxNext = lsbFirst ? {miso, rxShift[7:1]} : {rxShift[6:0], miso};
    rxByte = lsbFirst ? (rxNext >> (4'd8 - frameLen)) : rxNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txShift <= '0;
      rxShift <= '0;
    end else if (strobes.loadFrame) begin
      txShift <= txHead;
      rxShift <= '0;
    end else begin
      if (strobes.shiftOut) txShift <= lsbFirst ? (txShift >> 1) : (txShift << 1);
      rxShift <= rxNext;
    end
  end
endmodule

// File: rtl/spi_host_ctrl.sv
`timescale 1ns/1ps
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int NumCs = 4,
  parameter int DivW  = 12,
  parameter int CsIdW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       addr,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  input  logic             txEmpty,
  input  logic             txFull,
  input  logic             rxEmpty,
  input  logic             rxFull,
  input  logic [7:0]       rxHead,
  output dpStrobes_t       strobes,
  output logic [3:0]       frameLen,
  output logic             lsbFirst,
  output logic             sck,
  output logic [NumCs-1:0] csOut,
  output logic             busy
);
  logic [DivW-1:0]  divReg, divCnt;
  logic             pha, pol, lsbReg, dirReg, sckInt, holdOn;
  logic [CsIdW-1:0] csId;
  logic [NumCs-1:0] csDef, selHot;
  logic [1:0]       csPolicy, proto;
  logic [3:0]       lenReg, edgeCnt, lastIdx;
  logic             tick, leading, lastEdge, start, release_, assertCs;

  for (genvar i = 0; i < NumCs; i++) begin : g_sel
    assign selHot[i] = (csId == CsIdW'(i));
  end

  assign frameLen = (lenReg == 4'd0) ? 4'd1 : (lenReg > 4'd8) ? 4'd8 : lenReg;
  assign lsbFirst = lsbReg;
  assign lastIdx  = 4'((5'(frameLen) << 1) - 5'd1);
  assign tick     = busy && (divCnt >= divReg);
  assign leading  = !edgeCnt[0];
  assign lastEdge = (edgeCnt == lastIdx);
  assign start    = !busy && !txEmpty && !rxFull;

  assign strobes.txPush    = wrEn && addr == AdrTxData && !txFull;
  assign strobes.rxPop     = rdEn && addr == AdrRxData && !rxEmpty;
  assign strobes.loadFrame = start;
  assign strobes.sampleIn  = tick && (pha ? !leading : leading);
  assign strobes.shiftOut  = tick && (pha ? (leading && edgeCnt != 4'd0) : !leading);
  assign strobes.pushRx    = tick && lastEdge;

  assign release_ = (wrEn && addr == AdrCsPol && wrData[1:0] != csPolicy)
                 || (wrEn && addr == AdrCsId && wrData[CsIdW-1:0] != csId)
                 || (wrEn && addr == AdrCsDef && ((wrData[NumCs-1:0] ^ csDef) & selHot) != '0);

  always_comb begin
    case (csPolicy)
      CsOff:   assertCs = 1'b0;
      CsHold:  assertCs = busy || holdOn;
      default: assertCs = busy;
    endcase
  end

  assign csOut = csDef ^ (selHot & {NumCs{assertCs}});
  assign sck   = sckInt ^ pol;

  always_comb begin
    case (addr)
      AdrDiv:    rdData = 32'(divReg);
      AdrMode:   rdData = {30'b0, pol, pha};
      AdrCsId:   rdData = 32'(csId);
      AdrCsDef:  rdData = 32'(csDef);
      AdrCsPol:  rdData = {30'b0, csPolicy};
      AdrFmt:    rdData = {12'b0, lenReg, 12'b0, dirReg, lsbReg, proto};
      AdrTxData: rdData = {txFull, 31'b0};
      AdrRxData: rdData = {rxEmpty, 23'b0, rxEmpty ? 8'h00 : rxHead};
      default:   rdData = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divReg   <= DivW'(3);
      pha      <= 1'b0;
      pol      <= 1'b0;
      csId     <= '0;
      csDef    <= '1;
      csPolicy <= CsAuto;
      proto    <= 2'd0;
      lsbReg   <= 1'b0;
      dirReg   <= 1'b0;
      lenReg   <= 4'd8;
      busy     <= 1'b0;
      divCnt   <= '0;
      edgeCnt  <= '0;
      sckInt   <= 1'b0;
      holdOn   <= 1'b0;
    end else begin
      if (wrEn) begin
        case (addr)
          AdrDiv:   divReg <= wrData[DivW-1:0];
          AdrMode:  {pol, pha} <= wrData[1:0];
          AdrCsId:  csId <= wrData[CsIdW-1:0];
          AdrCsDef: csDef <= wrData[NumCs-1:0];
          AdrCsPol: csPolicy <= wrData[1:0];
          AdrFmt: begin
            proto  <= wrData[1:0];
            lsbReg <= wrData[2];
            dirReg <= wrData[3];
            lenReg <= wrData[19:16];
          end
          default: ;
        endcase
      end
      if (release_) holdOn <= 1'b0;
      else if (start && csPolicy == CsHold) holdOn <= 1'b1;
      if (start) begin
        busy    <= 1'b1;
        divCnt  <= '0;
        edgeCnt <= '0;
        sckInt  <= 1'b0;
      end else if (busy) begin
        if (tick) begin
          divCnt  <= '0;
          sckInt  <= !sckInt;
          edgeCnt <= edgeCnt + 4'd1;
          if (lastEdge) busy <= 1'b0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_host.sv
`timescale 1ns/1ps
module spi_host
  import spi_host_pkg::*;
#(
  parameter int NumCs = 4,
  parameter int DivW  = 12,
  parameter int CsIdW = 8,
  parameter int Depth = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [NumCs-1:0] csOut
);
  dpStrobes_t strobes;
  logic       engineBusy, txEmpty, txFull, rxEmpty, rxFull, lsbFirst;
  logic [7:0] rxHead;
  logic [3:0] frameLen;

  spi_host_ctrl #(.NumCs(NumCs), .DivW(DivW), .CsIdW(CsIdW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(busAddr), .wrEn(busWr), .rdEn(busRd),
    .wrData(busWdata), .rdData(busRdata), .txEmpty(txEmpty), .txFull(txFull),
    .rxEmpty(rxEmpty), .rxFull(rxFull), .rxHead(rxHead), .strobes(strobes),
    .frameLen(frameLen), .lsbFirst(lsbFirst), .sck(sck), .csOut(csOut),
    .busy(engineBusy));

  spi_host_dp #(.Depth(Depth)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrByte(busWdata[7:0]),
    .frameLen(frameLen), .lsbFirst(lsbFirst), .miso(miso), .mosi(mosi),
    .rxHead(rxHead), .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty),
    .rxFull(rxFull));
endmodule

// File: rtl/spi_host_checker.sv
`timescale 1ns/1ps
module spi_host_checker
  import spi_host_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busWr,
  input logic       sck,
  input logic       busy,
  input logic       txEmpty,
  input logic       txFull,
  input logic       rxEmpty,
  input logic       rxFull,
  input dpStrobes_t strobes
);
  p_sck_rests_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !busWr) |=> $stable(sck));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    txFull |-> !strobes.txPush);

  p_no_rx_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rxFull |-> !strobes.pushRx);

  p_pop_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.rxPop |-> !rxEmpty);

  p_frame_from_queue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!txEmpty));

  p_push_ends_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.pushRx |=> !busy);
endmodule

bind spi_host spi_host_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busWr(busWr), .sck(sck), .busy(engineBusy),
  .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull),
  .strobes(strobes));

// File: tb/spi_host_test.sv
`timescale 1ns/1ps
module spi_host_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sck, mosi, misoReg = 1'b0, loopMode = 1'b0;
  logic [3:0]  csOut;
  wire         misoWire = loopMode ? mosi : misoReg;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  logic       slvOn = 0, benchPol = 0, benchPha = 0, slvLsb = 0;
  int         slvIdx = 0, slvLen = 8, periodErr = 0;
  logic [7:0] slvByte = 0, slvCap = 0;
  logic [3:0] csDuring = 0;
  time        lastEdgeT = 0, halfExp = 8;
  bit         edgeSeen = 0;

  spi_host uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .sck(sck), .mosi(mosi),
    .miso(misoWire), .csOut(csOut));

  always #4 clk = !clk;

  always @(sck) begin
    if (slvOn) begin
      if (edgeSeen && (($time - lastEdgeT) != halfExp)) periodErr++;
      edgeSeen = 1;
      lastEdgeT = $time;
      if (sck == (benchPol ^ !benchPha)) begin
        if (slvIdx == 0) csDuring = csOut;
        if (slvLsb) slvCap[slvIdx] = mosi;
        else slvCap = {slvCap[6:0], mosi};
        slvIdx++;
        if (slvIdx < slvLen)
          misoReg = slvLsb ? slvByte[slvIdx] : slvByte[slvLen-1-slvIdx];
      end
    end
  end

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busPeek(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #1; d = busRdata;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1; #1; d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic waitRx();
    logic [31:0] d;
    for (int k = 0; k < 2000; k++) begin
      busPeek(8'h4C, d);
      if (!d[31]) return;
    end
  endtask

  function automatic int effLen(input int f);
    return (f == 0) ? 1 : (f > 8) ? 8 : f;
  endfunction

  // one frame against the bench slave; config already written
  task automatic runFrame(input logic [7:0] tx, input logic [7:0] sb, input int n,
                          input logic lsb, input int div, output logic [7:0] rx,
                          output logic [7:0] cap);
    logic [31:0] d;
    slvByte = sb; slvLen = n; slvLsb = lsb; slvIdx = 0; slvCap = 0;
    misoReg = lsb ? sb[0] : sb[n-1];
    halfExp = (div + 1) * 8; edgeSeen = 0; periodErr = 0;
    slvOn = 1;
    busWrite(8'h48, {24'b0, tx});
    waitRx();
    slvOn = 0;
    busRead(8'h4C, d);
    rx = d[7:0];
    cap = slvCap;
  endtask

  task automatic setMode(input int m);
    benchPha = m[0]; benchPol = m[1];
    busWrite(8'h04, m);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] rx, cap, tx, sb, mask;
    int idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values and readback
    busPeek(8'h00, d); checkEq("R1 div reset", d, 32'd3);
    busPeek(8'h04, d); checkEq("R1 mode reset", d, 32'd0);
    busPeek(8'h10, d); checkEq("R1 csid reset", d, 32'd0);
    busPeek(8'h14, d); checkEq("R1 csdef reset", d, 32'hF);
    busPeek(8'h18, d); checkEq("R1 policy reset", d, 32'd0);
    busPeek(8'h40, d); checkEq("R1 fmt reset", d, 32'h0008_0000);
    busPeek(8'h48, d); checkEq("R1 tx reset", d, 32'd0);
    busPeek(8'h4C, d); checkEq("R1 rx reset", d, 32'h8000_0000);
    busWrite(8'h60, 32'hFFFF_FFFF);
    busPeek(8'h60, d); checkEq("R1 flash ctrl zero", d, 32'd0);
    busWrite(8'h00, 32'h0000_1234);
    busPeek(8'h00, d); checkEq("R1 div masked", d, 32'h234);
    checkEq("R2 idle sck", {31'b0, sck}, 32'd0);

    // R2 R3 R4 R5 sweep: lengths, modes, bit order, divisors
    idx = 0;
    for (int n = 1; n <= 8; n++) begin
      for (int m = 0; m < 4; m++) begin
        for (int l = 0; l < 2; l++) begin
          int dv;
          dv = idx % 3;
          setMode(m);
          busWrite(8'h00, dv);
          busWrite(8'h40, (n << 16) | (l << 2));
          tx = 8'hA5 ^ 8'(idx * 37);
          sb = 8'h3C + 8'(idx * 11);
          mask = 8'((1 << n) - 1);
          runFrame(tx, sb, n, l[0], dv, rx, cap);
          checkEq("R5 rx byte", {24'b0, rx}, {24'b0, sb & mask});
          checkEq("R3 R4 mosi bits", {24'b0, cap}, {24'b0, tx & mask});
          checkEq("R2 half period", periodErr, 0);
          checkEq("R2 idle level", {31'b0, sck}, {31'b0, benchPol});
          idx++;
        end
      end
    end

    // R4 length clamp
    setMode(0);
    busWrite(8'h00, 1);
    busWrite(8'h40, 32'h0000_0000);
    runFrame(8'hFF, 8'h01, effLen(0), 1'b0, 1, rx, cap);
    checkEq("R4 len0 rx", {24'b0, rx}, 32'h01);
    checkEq("R4 len0 tx", {24'b0, cap}, 32'h01);
    busWrite(8'h40, 32'h000F_0004);
    runFrame(8'h96, 8'hC3, effLen(15), 1'b1, 1, rx, cap);
    checkEq("R4 len15 rx", {24'b0, rx}, 32'hC3);
    checkEq("R4 len15 tx", {24'b0, cap}, 32'h96);

    // R6 R7 queues with loopback
    busWrite(8'h00, 0);
    busWrite(8'h40, 32'h0008_0000);
    loopMode = 1'b1;
    for (int k = 0; k < 8; k++) busWrite(8'h48, 8'h10 + k);
    repeat (300) @(negedge clk);
    busPeek(8'h48, d); checkEq("R7 tx drained while rx fills", d, 32'd0);
    for (int k = 0; k < 8; k++) busWrite(8'h48, 8'h40 + k);
    busPeek(8'h48, d); checkEq("R6 tx full flag", d, 32'h8000_0000);
    busWrite(8'h48, 32'hEE);
    repeat (60) @(negedge clk);
    busPeek(8'h48, d); checkEq("R7 stalled while rx full", d, 32'h8000_0000);
    for (int k = 0; k < 8; k++) begin
      busRead(8'h4C, d);
      checkEq("R7 order first batch", d, 32'h10 + k);
    end
    repeat (300) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      busRead(8'h4C, d);
      checkEq("R7 order second batch", d, 32'h40 + k);
    end
    repeat (100) @(negedge clk);
    busPeek(8'h4C, d); checkEq("R6 dropped write left no frame", d, 32'h8000_0000);
    busPeek(8'h48, d); checkEq("R6 tx not full", d, 32'd0);
    loopMode = 1'b0;

    // R8 auto policy
    busWrite(8'h10, 2);
    runFrame(8'h5A, 8'h33, 8, 1'b0, 0, rx, cap);
    checkEq("R8 cs during", {28'b0, csDuring}, 32'b1011);
    checkEq("R8 cs after", {28'b0, csOut}, 32'b1111);

    // R9 hold policy
    busWrite(8'h18, 2);
    runFrame(8'h5A, 8'h33, 8, 1'b0, 0, rx, cap);
    checkEq("R9 cs during", {28'b0, csDuring}, 32'b1011);
    checkEq("R9 cs held", {28'b0, csOut}, 32'b1011);
    busWrite(8'h10, 2);
    checkEq("R9 same id keeps hold", {28'b0, csOut}, 32'b1011);
    busWrite(8'h10, 1);
    checkEq("R9 id change releases", {28'b0, csOut}, 32'b1111);
    runFrame(8'h11, 8'h22, 8, 1'b0, 0, rx, cap);
    checkEq("R9 held line1", {28'b0, csOut}, 32'b1101);
    busWrite(8'h14, 32'b0111);
    checkEq("R9 other default keeps hold", {28'b0, csOut}, 32'b0101);
    busWrite(8'h14, 32'b0101);
    busWrite(8'h14, 32'b0001);
    checkEq("R9 selected default releases", {28'b0, csOut}, 32'b0001);
    busWrite(8'h14, 32'b1111);
    runFrame(8'h11, 8'h22, 8, 1'b0, 0, rx, cap);
    busWrite(8'h18, 2);
    checkEq("R9 same policy keeps hold", {28'b0, csOut}, 32'b1101);
    busWrite(8'h18, 0);
    checkEq("R9 policy change releases", {28'b0, csOut}, 32'b1111);

    // R10 off policy
    busWrite(8'h18, 3);
    runFrame(8'h77, 8'h9D, 8, 1'b0, 0, rx, cap);
    checkEq("R10 no cs during", {28'b0, csDuring}, 32'b1111);
    checkEq("R10 rx still works", {24'b0, rx}, 32'h9D);

    // R11 idle levels and out-of-range id
    busWrite(8'h18, 0);
    busWrite(8'h10, 5);
    runFrame(8'h77, 8'h9D, 8, 1'b0, 0, rx, cap);
    checkEq("R11 id beyond lines", {28'b0, csDuring}, 32'b1111);
    busWrite(8'h10, 0);
    busWrite(8'h14, 32'b1010);
    checkEq("R11 idle levels", {28'b0, csOut}, 32'b1010);
    runFrame(8'h77, 8'h9D, 8, 1'b0, 0, rx, cap);
    checkEq("R11 inverted active level", {28'b0, csDuring}, 32'b1011);
    checkEq("R11 back to idle", {28'b0, csOut}, 32'b1010);

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule